// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks branch divergence for a single warp of parallel lanes. When the decoder issues a split, the block compares each lane's branch predicate against the lanes that are active now. If the active lanes disagree, the taken lanes run first. The not-taken lanes and the fall-through PC wait on a small LIFO stack, above an entry that holds the mask to come back to. Each join pops one entry. A pending-path entry switches the warp to the waiting lanes and sends a one-cycle redirect to fetch. A reconvergence entry restores the full mask from before the split. When every active lane agrees, the split does not serialise anything. It stores a marker entry, so the matching join pops quietly.

The stack holds four entries. A divergent split uses two entries and an agreeing split uses one. A split without enough free space, or a join on an empty stack, is refused. A refused operation sets a sticky error and changes nothing else. Loops in which lanes run different iteration counts must be removed before code reaches this block.

The controller is a state machine over stack occupancy, with three states:
- ST_EMPTY: no entries.
- ST_PARTIAL: some entries, but not all.
- ST_FULL: all entries in use.

Its transitions are named as follows:
- T_SPLIT_PUSH: one or two pushes. It moves from EMPTY or PARTIAL to PARTIAL or FULL.
- T_JOIN_POP: one pop. It moves from FULL or PARTIAL to PARTIAL or EMPTY.
- T_HOLD: no operation, a reserved code, or a refused operation. The state stays the same.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `active_mask` is all ones, `redirect_valid` is 0 and `stack_err` is 0.
- R2: `rs_op` uses these codes: 2'b01 is split, 2'b10 is join, and 2'b00 and 2'b11 have no effect. When a split sees disagreeing active lanes, `active_mask` becomes (`branch_pred` & old mask) on the cycle after it. No redirect is raised.
- R3: When a split sees active lanes that are all taken or all not-taken, `active_mask` is unchanged and one stack entry is used.
- R4: A join that pops a pending-path entry sets `active_mask` to that split's not-taken lanes. It also raises `redirect_valid` for exactly one cycle, with `redirect_pc` equal to the `fall_pc` given at that split.
- R5: A join that pops a reconvergence entry restores the mask that was active before the matching divergent split. It raises no redirect.
- R6: A join that pops a marker entry leaves `active_mask` unchanged and raises no redirect.
- R7: A split is refused in two cases: a divergent split when fewer than two entries are free, or an agreeing split when the stack is full. A refused split sets `stack_err` and leaves the mask and the stack contents unchanged.
- R8: A join on an empty stack sets `stack_err`. It leaves `active_mask` unchanged and raises no redirect.
- R9: `stack_err` stays at 1 until reset, and normal operation continues while it is set.
- R10: Entries leave in last-in first-out order. Up to four entries can be held, which allows two nested divergent splits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs_op | input | 2 | 01 split, 10 join, other codes no operation |
| branch_pred | input | LANES | Per-lane branch outcome for a split |
| fall_pc | input | PC_W | Fall-through PC saved for the not-taken lanes |
| active_mask | output | LANES | Lanes enabled for execution |
| redirect_valid | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | PC_W | Redirect target, valid with `redirect_valid` |
| stack_err | output | 1 | Sticky overflow or underflow flag |

## Verification
A stack pointer that is off by one, or an entry with the wrong kind, stays hidden until the join that reads it. Then it shows up as a wrong mask, a missing or extra redirect pulse, or a wrong redirect target, one cycle after that join. The vector walk unwinds two nested divergences and two markers, so every entry kind is read back at the ports. The overflow tests then pop the stack after a refused split. A corrupted entry from the refused split appears on the very next join.

// File: rtl/simt_rs_pkg.sv
package simt_rs_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_SPLIT = 2'b01,
        OP_JOIN  = 2'b10,
        OP_RSVD  = 2'b11
    } rs_op_e;

    typedef enum logic [1:0] {
        EK_MARK    = 2'b00,
        EK_RECONV  = 2'b01,
        EK_PENDING = 2'b10
    } ent_kind_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'b00,
        ST_PARTIAL = 2'b01,
        ST_FULL    = 2'b10
    } occ_state_e;

endpackage

// File: rtl/rs_split_eval.sv
module rs_split_eval #(
    parameter int unsigned LANES = 8
) (
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] pred,
    output logic [LANES-1:0] taken,
    output logic [LANES-1:0] not_taken,
    output logic             divergent
);
    always_comb begin
        taken     = cur_mask & pred;
        not_taken = cur_mask & ~pred;
        divergent = (|taken) && (|not_taken);
    end
endmodule

// File: rtl/rs_lifo.sv
module rs_lifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_one,
    input  logic                       push_two,
    input  logic                       pop,
    input  logic [W-1:0]               din_lo,
    input  logic [W-1:0]               din_hi,
    output logic [W-1:0]               top,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] wr0, wr1, rd;

    always_comb begin
        wr0 = IW'(count);
        wr1 = IW'(count + CW'(1));
        rd  = IW'(count - CW'(1));
        top = mem[rd];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (pop) begin
            count <= count - CW'(1);
        end else if (push_two) begin
            mem[wr0] <= din_lo;
            mem[wr1] <= din_hi;
            count    <= count + CW'(2);
        end else if (push_one) begin
            mem[wr0] <= din_lo;
            count    <= count + CW'(1);
        end
    end

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_two |-> (count <= CW'(DEPTH - 2)));
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_rs_pkg::*;
#(
    parameter int unsigned LANES = 8,
    parameter int unsigned PC_W  = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rs_op,
    input  logic [LANES-1:0] branch_pred,
    input  logic [PC_W-1:0]  fall_pc,
    output logic [LANES-1:0] active_mask,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             stack_err
);
    localparam int unsigned EW = 2 + LANES + PC_W;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    rs_op_e     op;
    occ_state_e state, state_nxt;

    logic [LANES-1:0] taken, not_taken;
    logic             divergent;
    logic [EW-1:0]    din_lo, din_hi, top;
    logic [CW-1:0]    count;
    logic             is_split, is_join, split_ok, join_ok, err_evt;
    logic             push_one, push_two, pop;
    ent_kind_e        top_kind;
    logic [LANES-1:0] top_mask;
    logic [PC_W-1:0]  top_pc;

    assign op = rs_op_e'(rs_op);

    rs_split_eval #(.LANES(LANES)) u_eval (
        .cur_mask (active_mask),
        .pred     (branch_pred),
        .taken    (taken),
        .not_taken(not_taken),
        .divergent(divergent)
    );

    rs_lifo #(.DEPTH(DEPTH), .W(EW)) u_lifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_one(push_one),
        .push_two(push_two),
        .pop     (pop),
        .din_lo  (din_lo),
        .din_hi  (din_hi),
        .top     (top),
        .count   (count)
    );

    always_comb begin
        top_kind = ent_kind_e'(top[EW-1 -: 2]);
        top_mask = top[PC_W +: LANES];
        top_pc   = top[PC_W-1:0];
        is_split = (op == OP_SPLIT);
        is_join  = (op == OP_JOIN);
        split_ok = 1'b0;
        join_ok  = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                split_ok = is_split;
            end
            ST_PARTIAL: begin
                split_ok = is_split && (!divergent || count != CW'(DEPTH - 1));
                join_ok  = is_join;
            end
            ST_FULL: begin
                join_ok  = is_join;
            end
            default: ;
        endcase
        err_evt  = (is_split && !split_ok) || (is_join && !join_ok);
        push_two = split_ok && divergent;
        push_one = split_ok && !divergent;
        pop      = join_ok;
        din_lo   = {(divergent ? EK_RECONV : EK_MARK), active_mask, {PC_W{1'b0}}};
        din_hi   = {EK_PENDING, not_taken, fall_pc};
    end

    // next occupancy state: T_SPLIT_PUSH, T_JOIN_POP, T_HOLD
    always_comb begin
        logic [CW:0] nxt;
        nxt = {1'b0, count};
        if (pop)           nxt = nxt - 1'b1;
        else if (push_two) nxt = nxt + 2'd2;
        else if (push_one) nxt = nxt + 1'b1;
        if (nxt == '0)                  state_nxt = ST_EMPTY;
        else if (nxt >= (CW+1)'(DEPTH)) state_nxt = ST_FULL;
        else                            state_nxt = ST_PARTIAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_mask    <= '1;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            stack_err      <= 1'b0;
        end else begin
            redirect_valid <= 1'b0;
            if (err_evt) stack_err <= 1'b1;
            if (push_two) begin
                active_mask <= taken;
            end else if (pop) begin
                active_mask <= top_mask;
                if (top_kind == EK_PENDING) begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= top_pc;
                end
            end
        end
    end

    p_state_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) == (count == '0));
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);
    p_redirect_join_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ($past(rs_op) == 2'b10));
    p_split_no_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_op == 2'b01) |=> !redirect_valid);
    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_join && state == ST_EMPTY) |=> (stack_err && $stable(active_mask) && !redirect_valid));
    p_unanimous_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_split && !divergent) |=> $stable(active_mask));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_split && state == ST_FULL) |=> (stack_err && $stable(active_mask)));
endmodule

// File: tb/test_simt_reconv_stack.sv
module test_simt_reconv_stack;
    localparam int LANES = 8;
    localparam int PC_W  = 16;
    localparam int NV    = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       rs_op = 2'b00;
    logic [LANES-1:0] branch_pred = '0;
    logic [PC_W-1:0]  fall_pc = '0;
    logic [LANES-1:0] active_mask;
    logic             redirect_valid;
    logic [PC_W-1:0]  redirect_pc;
    logic             stack_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(4)) i_simt_reconv_stack (
        .clk(clk), .rst_n(rst_n), .rs_op(rs_op), .branch_pred(branch_pred),
        .fall_pc(fall_pc), .active_mask(active_mask), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .stack_err(stack_err)
    );

    // {op, pred, pc, exp_mask, exp_rv, exp_rpc, exp_err}
    localparam logic [51:0] VEC [NV] = '{
        {2'b01, 8'h0F, 16'h0100, 8'h0F, 1'b0, 16'h0000, 1'b0}, // R2 divergent
        {2'b01, 8'h03, 16'h0200, 8'h03, 1'b0, 16'h0000, 1'b0}, // R10 nested, full
        {2'b10, 8'h00, 16'h0000, 8'h0C, 1'b1, 16'h0200, 1'b0}, // R4 inner pending
        {2'b10, 8'h00, 16'h0000, 8'h0F, 1'b0, 16'h0000, 1'b0}, // R5 inner reconv
        {2'b10, 8'h00, 16'h0000, 8'hF0, 1'b1, 16'h0100, 1'b0}, // R4 outer pending
        {2'b01, 8'hFF, 16'h0300, 8'hF0, 1'b0, 16'h0000, 1'b0}, // R3 all taken
        {2'b01, 8'h0F, 16'h0400, 8'hF0, 1'b0, 16'h0000, 1'b0}, // R3 none taken
        {2'b11, 8'h55, 16'h0500, 8'hF0, 1'b0, 16'h0000, 1'b0}, // R2 reserved code
        {2'b10, 8'h00, 16'h0000, 8'hF0, 1'b0, 16'h0000, 1'b0}, // R6 marker
        {2'b10, 8'h00, 16'h0000, 8'hF0, 1'b0, 16'h0000, 1'b0}, // R6 marker
        {2'b10, 8'h00, 16'h0000, 8'hFF, 1'b0, 16'h0000, 1'b0}  // R5 outer reconv
    };
    string vreq [NV] = '{"R2", "R10", "R4", "R5", "R4", "R3", "R3", "R2", "R6", "R6", "R5"};

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [7:0] pred, input logic [15:0] pc);
        @(negedge clk);
        rs_op = op; branch_pred = pred; fall_pc = pc;
        @(posedge clk);
        @(negedge clk);
        rs_op = 2'b00;
    endtask

    task automatic expect_out(input string req, input logic [7:0] m,
                              input logic rv, input logic [15:0] pc, input logic e);
        check(req, "active_mask", 32'(active_mask), 32'(m));
        check(req, "redirect_valid", 32'(redirect_valid), 32'(rv));
        if (rv) check(req, "redirect_pc", 32'(redirect_pc), 32'(pc));
        check(req, "stack_err", 32'(stack_err), 32'(e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rs_op = 2'b00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        expect_out("R1", 8'hFF, 1'b0, 16'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][51:50], VEC[i][49:42], VEC[i][41:26]);
            expect_out(vreq[i], VEC[i][25:18], VEC[i][17], VEC[i][16:1], VEC[i][0]);
        end
        // R4: redirect pulse lasts one cycle
        apply(2'b10, 8'h00, 16'h0);           // underflow join, R8
        expect_out("R8", 8'hFF, 1'b0, 16'h0, 1'b1);

        // R9: flag sticky, operation continues
        apply(2'b01, 8'h01, 16'h0700);
        expect_out("R9", 8'h01, 1'b0, 16'h0, 1'b1);
        apply(2'b10, 8'h00, 16'h0);
        expect_out("R9", 8'hFE, 1'b1, 16'h0700, 1'b1);
        @(negedge clk);
        check("R4", "redirect single cycle", 32'(redirect_valid), 32'h0);
        apply(2'b10, 8'h00, 16'h0);
        expect_out("R9", 8'hFF, 1'b0, 16'h0, 1'b1);

        do_reset();
        expect_out("R1", 8'hFF, 1'b0, 16'h0, 1'b0);

        // R7: divergent split on full stack
        apply(2'b01, 8'h0F, 16'h0100);
        apply(2'b01, 8'h03, 16'h0200);
        apply(2'b01, 8'h01, 16'h0900);
        expect_out("R7", 8'h03, 1'b0, 16'h0, 1'b1);
        apply(2'b01, 8'hFF, 16'h0A00);        // agreeing split on full stack
        expect_out("R7", 8'h03, 1'b0, 16'h0, 1'b1);
        apply(2'b10, 8'h00, 16'h0);
        expect_out("R7", 8'h0C, 1'b1, 16'h0200, 1'b1);

        do_reset();
        // R7: divergent split with only one free entry
        apply(2'b01, 8'h0F, 16'h0100);
        apply(2'b01, 8'hFF, 16'h0B00);
        apply(2'b01, 8'h01, 16'h0C00);
        expect_out("R7", 8'h0F, 1'b0, 16'h0, 1'b1);
        apply(2'b10, 8'h00, 16'h0);
        expect_out("R6", 8'h0F, 1'b0, 16'h0, 1'b1);
        apply(2'b10, 8'h00, 16'h0);
        expect_out("R10", 8'hF0, 1'b1, 16'h0100, 1'b1);
        apply(2'b10, 8'h00, 16'h0);
        expect_out("R5", 8'hFF, 1'b0, 16'h0, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule